// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single register transactions against an Ethernet PHY over the two-wire management bus, which has a clock line and a bidirectional data line. The host presents a 5-bit PHY address, a 5-bit register address, a read/write flag and, for a write, 16 bits of data. It then pulses `start` for one cycle. The block builds the management clock by dividing the system clock. It puts out a full frame: preamble, start code, opcode, both addresses, turnaround and data. Finally it releases the line for one idle clock and reports completion with a single-cycle `done`.

The data line is modelled as a separate output value (`mdo`), an output enable (`mdo_en`) and an input (`mdi`). A pad outside this block combines them. Every bit period is a low half followed by a high half, and each half lasts `HALF_DIV` system clocks. Output values change only when a low half begins. Read data is sampled at the system edge that ends a high half, so it is taken while the management clock is still high.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc`, `mdo`, `mdo_en` and `done` are 0 and `rdata` keeps its last value (0 after reset).
- R2: A start pulse seen while idle begins a frame on the next system clock. Bit times 0 to 31 of the frame drive the line high as preamble.
- R3: Bit times 32 and 33 drive the start code 0 then 1. Bit times 34 and 35 drive the opcode: 1,0 when `op_wr`=0 (read) and 0,1 when `op_wr`=1 (write).
- R4: Bit times 36 to 40 drive the PHY address and bit times 41 to 45 drive the register address, each most significant bit first.
- R5: In a write, bit times 46 and 47 release the line (`mdo_en`=0). Bit times 48 to 63 drive `wdata` MSB first. Whenever `mdo_en` is 0, `mdo` is 0.
- R6: In a read, bit times 46 to 63 release the line. `mdi` is sampled at the end of the high half of bit times 48 to 63, and the samples are assembled MSB first.
- R7: Each bit time is `HALF_DIV` system clocks with `mdc`=0 followed by `HALF_DIV` clocks with `mdc`=1. `mdo` and `mdo_en` change only where a low half begins.
- R8: Bit time 64 is a released idle clock with `mdc` toggling normally. After it, the interface returns to the idle levels of R1.
- R9: `done` is high for exactly one system clock, 130·`HALF_DIV` clocks after the edge that accepted `start`. A read updates `rdata` in that same cycle; a write leaves `rdata` unchanged.
- R10: A `start` pulse during a frame is ignored, and input changes during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| op_wr | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| mdi | input | 1 | Data line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data value to drive onto the line |
| mdo_en | output | 1 | Output enable for the data line |
| rdata | output | 16 | Last read result |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
A start accepted at one edge shows up in the clock and data outputs from the very next system cycle. From there every output follows a fixed offset `t` from that edge. The bit time is `t / (2·HALF_DIV)` and the clock phase is `(t / HALF_DIV) mod 2`. `done` and the new `rdata` appear when `t` reaches 130·`HALF_DIV`. The bench keeps its own count of `t`, builds the expected 64-bit frame and enable mask by concatenating the requested fields, and compares all outputs on every falling system edge, half a cycle away from the edges that change them. The PHY read data is presented on `mdi` only inside the sampled window, and other values are presented outside it, so a sample taken in the wrong bit or the wrong phase shows up as a wrong `rdata`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 32;
    localparam int IDX_W     = 7;
    // bit time boundaries of the frame
    localparam int SOF_POS   = PRE_BITS;          // start code
    localparam int OPC_POS   = SOF_POS + 2;       // opcode
    localparam int PHY_POS   = OPC_POS + 2;       // PHY address
    localparam int REG_POS   = PHY_POS + ADDR_W;  // register address
    localparam int TA_POS    = REG_POS + ADDR_W;  // turnaround
    localparam int DAT_POS   = TA_POS + 2;        // data field
    localparam int IDLE_POS  = DAT_POS + DATA_W;  // trailing released clock

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] rga;
        logic [DATA_W-1:0] wdat;
    } mdio_cmd_t;

    typedef struct packed {
        logic en;
        logic val;
    } line_drv_t;

    function automatic line_drv_t bit_drive(mdio_cmd_t c, logic [IDX_W-1:0] idx);
        line_drv_t d;
        int i;
        i = int'(idx);
        d.en  = 1'b1;
        d.val = 1'b1;
        if (i < SOF_POS) begin
            d.val = 1'b1;
        end else if (i < OPC_POS) begin
            d.val = (i == SOF_POS + 1);
        end else if (i < PHY_POS) begin
            d.val = (i == OPC_POS) ? ~c.wr : c.wr;
        end else if (i < REG_POS) begin
            d.val = c.phy[REG_POS - 1 - i];
        end else if (i < TA_POS) begin
            d.val = c.rga[TA_POS - 1 - i];
        end else if (i < DAT_POS) begin
            d.en  = 1'b0;
        end else if (i < IDLE_POS) begin
            d.en  = c.wr;
            d.val = c.wdat[IDLE_POS - 1 - i];
        end else begin
            d.en  = 1'b0;
        end
        d.val = d.val & d.en;
        return d;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_hi,
    output logic end_hi
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          hi;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            hi  <= ~hi;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase_hi = hi;
    assign end_hi   = run && hi && (cnt == LAST);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd_in,
    input  logic              end_hi,
    input  logic              mdi,
    output logic              busy,
    output logic              drv_en,
    output logic              drv_val,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic [IDX_W-1:0]  bit_idx;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] shreg;
    line_drv_t         drv;
    logic              in_window;

    assign in_window = (int'(bit_idx) >= DAT_POS) && (int'(bit_idx) < IDLE_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            cmd     <= '0;
            shreg   <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    bit_idx <= '0;
                    cmd     <= cmd_in;
                end
            end else if (end_hi) begin
                if (!cmd.wr && in_window)
                    shreg <= {shreg[DATA_W-2:0], mdi};
                if (int'(bit_idx) == IDLE_POS) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!cmd.wr)
                        rdata <= shreg;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        drv     = bit_drive(cmd, bit_idx);
        drv_en  = busy & drv.en;
        drv_val = busy & drv.val;
    end

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(bit_idx) <= IDLE_POS);                                    // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R9
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy) && !busy);                                // R9

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_wr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdi,
    output logic        mdc,
    output logic        mdo,
    output logic        mdo_en,
    output logic [15:0] rdata,
    output logic        done
);
    mdio_cmd_t cmd_in;
    logic      busy;
    logic      phase_hi;
    logic      end_hi;

    assign cmd_in = '{wr: op_wr, phy: phy_addr, rga: reg_addr, wdat: wdata};

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .phase_hi (phase_hi),
        .end_hi   (end_hi)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd_in  (cmd_in),
        .end_hi  (end_hi),
        .mdi     (mdi),
        .busy    (busy),
        .drv_en  (mdo_en),
        .drv_val (mdo),
        .rdata   (rdata),
        .done    (done)
    );

    assign mdc = busy & phase_hi;

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdo) && $stable(mdo_en));                      // R7
    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (rst)
        !mdo_en |-> !mdo);                                             // R5
    AST_IDLE_CLOCK_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mdc) && !$past(mdo_en) && !mdc);                // R8

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int H     = 3;
    localparam int FRAME = 130 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        mdi;
    logic        mdc, mdo, mdo_en, done;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(H)) dut (
        .clk(clk), .rst(rst), .start(start), .op_wr(op_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .mdi(mdi), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en),
        .rdata(rdata), .done(done)
    );

    // reference model
    logic        m_busy = 1'b0;
    logic        m_done = 1'b0;
    logic        m_wr   = 1'b0;
    int          m_t    = 0;
    logic [63:0] m_val  = '0;
    logic [63:0] m_en   = '0;
    logic [15:0] m_rdata = '0;
    logic [15:0] phy_word = '0;

    function automatic int m_bit();
        return m_t / (2 * H);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy  <= 1'b0;
            m_done  <= 1'b0;
            m_t     <= 0;
            m_rdata <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1;
                    m_t    <= 0;
                    m_wr   <= op_wr;
                    m_val  <= {32'hFFFF_FFFF, 2'b01, (op_wr ? 2'b01 : 2'b10),
                               phy_addr, reg_addr, 2'b00, (op_wr ? wdata : 16'h0)};
                    m_en   <= {{46{1'b1}}, 2'b00, (op_wr ? 16'hFFFF : 16'h0000)};
                end
            end else if (m_t == FRAME - 1) begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                if (!m_wr) m_rdata <= phy_word;
            end else begin
                m_t <= m_t + 1;
            end
        end
    end

    // PHY side: valid read data only in the sampled window, junk elsewhere
    assign mdi = (m_busy && !m_wr && m_bit() >= 48 && m_bit() <= 63)
                 ? phy_word[63 - m_bit()] : ~m_t[0];

    function automatic string tag_now();
        int b;
        if (!m_busy) return "R1";
        b = m_bit();
        if (b < 32) return "R2";
        if (b < 36) return "R3";
        if (b < 46) return "R4";
        if (b < 64) return m_wr ? "R5" : "R6";
        return "R8";
    endfunction

    always @(negedge clk) begin
        logic e_mdc, e_en, e_val;
        int b;
        cyc = cyc + 1;
        if (!rst) begin
            e_mdc = 1'b0; e_en = 1'b0; e_val = 1'b0;
            if (m_busy) begin
                b     = m_bit();
                e_mdc = ((m_t / H) % 2) == 1;
                if (b < 64) begin
                    e_en  = m_en[63 - b];
                    e_val = m_val[63 - b] & e_en;
                end
            end
            n_checks++;
            if (mdc !== e_mdc) begin
                n_fail++;
                $display("FAIL R7 mdc at t=%0d: got %b expected %b", m_t, mdc, e_mdc);
            end else if (mdo_en !== e_en || mdo !== e_val) begin
                n_fail++;
                $display("FAIL %s line at t=%0d: got en=%b val=%b expected en=%b val=%b",
                         tag_now(), m_t, mdo_en, mdo, e_en, e_val);
            end else if (done !== m_done || rdata !== m_rdata) begin
                n_fail++;
                $display("FAIL R9 done/rdata: got %b/%h expected %b/%h",
                         done, rdata, m_done, m_rdata);
            end
        end
    end

    task automatic issue(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd);
        @(negedge clk);
        op_wr = wr; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    task automatic check_rdata(input string tag, input logic [15:0] exp);
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s rdata: got %h expected %h", tag, rdata, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (mdc !== 1'b0 || mdo !== 1'b0 || mdo_en !== 1'b0 || done !== 1'b0 || rdata !== 16'h0) begin
            n_fail++;
            $display("FAIL R1 reset: got %b%b%b%b %h expected 0000 0000", mdc, mdo, mdo_en, done, rdata);
        end
        // R2 R3 R4 R5: write frame
        issue(1'b1, 5'h11, 5'h0A, 16'hA53C);
        wait_frame();
        // R6: read frame
        phy_word = 16'h8001;
        issue(1'b0, 5'h1F, 5'h00, 16'hFFFF);
        wait_frame();
        check_rdata("R6", 16'h8001);
        // R10: start and inputs changed mid-frame are ignored
        phy_word = 16'hC35A;
        issue(1'b0, 5'h05, 5'h1B, 16'h0000);
        repeat (100) @(negedge clk);
        issue(1'b1, 5'h00, 5'h1F, 16'h1234);
        op_wr = 1'b1; phy_addr = 5'h0; wdata = 16'hFFFF;
        wait_frame();
        check_rdata("R10", 16'hC35A);
        // R9: write leaves rdata; start in the cycle done is high
        issue(1'b1, 5'h00, 5'h00, 16'h0000);
        while (!done) @(negedge clk);
        start = 1'b1; op_wr = 1'b1; phy_addr = 5'h15; reg_addr = 5'h15; wdata = 16'h5555;
        @(negedge clk);
        start = 1'b0;
        check_rdata("R9", 16'hC35A);
        wait_frame();
        // R1 R8: idle after frames
        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule